// File: doc/BRIEF.md
# Parallel Multi-Bank Block Erase Scheduler

This block erases one block address on up to four flash banks so that the long erase times run side by side. A single start strobe latches a row address and a mask of the banks that are fitted. The scheduler then makes an issue pass. For each fitted bank, in ascending bank order, it sends an erase setup command, the row address as a series of byte cycles and an erase confirm. It does not wait for any bank to become ready during this pass. It then makes a completion pass, polling the status of each surviving bank in turn until that bank reports ready or runs out of polls.

The commands reach the per-bank bus sequencer through a simple request/acknowledge handshake. The scheduler holds one operation (code, bank, data byte) steady until the sequencer acknowledges it. With the acknowledge, the sequencer returns an error flag, and for status polls a ready flag. Any bank that fails a step is marked in a per-bank failure mask. All of its remaining steps are skipped. When the last bank finishes, a one-cycle done pulse is raised, and the mask stays valid until the next start.

Top module: `erase_sched`

## Requirements
- R1: While reset is held and right after it, `done`, `op_valid` and `fail_mask` are all zero.
- R2: In the issue pass, each fitted bank receives, in ascending bank order, op code 0 (setup, data 0). It then receives ADDR_CYCLES ops with code 1 that carry the row address low byte first. Last comes code 2 (confirm, data 0). Every issue op of every bank comes before the first status op, which has code 3 and data 0.
- R3: While `op_valid` is high and `op_ack` is low, the op code, bank and data stay unchanged on the next cycle.
- R4: A bank whose bit in the latched fitted mask is zero never appears on `op_bank`, in either pass.
- R5: An acknowledge with `op_err` high during the issue pass sets that bank's bit in `fail_mask`. The bank then receives no more issue ops and no status polls.
- R6: In the completion pass, a status op acknowledged with `op_ready` low is re-issued to the same bank. An acknowledge with `op_ready` high ends that bank without setting its failure bit.
- R7: A bank whose POLL_LIMIT-th status poll is still not ready gets its failure bit set, and the scheduler moves on. A status acknowledge with `op_err` high also sets the bit at once.
- R8: `fail_mask` bit i is 1 exactly when bank i failed. It is cleared by an accepted start and holds its final value after `done` until the next accepted start.
- R9: `done` is high for exactly one cycle, namely the cycle after the acknowledge of the last operation. `op_valid` is low in that cycle.
- R10: A start that arrives while operations are in progress is ignored. The sequence, row address and fitted mask of the run in progress are unchanged.
- R11: A start with an all-zero fitted mask issues no operation. It raises `done` in the next cycle with `fail_mask` zero.
- R12: The row address is sampled only on the accepted start. Later changes to `row_addr` do not alter the address bytes that are sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start strobe, accepted only when idle |
| row_addr | input | 8*ADDR_CYCLES | Block row address to erase |
| bank_present | input | NBANK | Fitted-bank mask, bit i = bank i |
| done | output | 1 | One-cycle completion pulse |
| fail_mask | output | NBANK | Per-bank failure result, bit i = bank i failed |
| op_valid | output | 1 | Operation request to the bus sequencer |
| op_code | output | 2 | 0 setup, 1 address byte, 2 confirm, 3 status poll |
| op_bank | output | log2(NBANK) | Target bank of the operation |
| op_data | output | 8 | Address byte for code 1, otherwise 0 |
| op_ack | input | 1 | Sequencer accepted and finished the operation |
| op_err | input | 1 | Operation failed, valid with op_ack |
| op_ready | input | 1 | Status poll saw the bank ready, valid with op_ack |

## Verification
Each operation is registered. After an acknowledge, the next operation is presented in the following cycle, so the bench compares each operation against its own expected list in the cycle it acknowledges it, and sampling falls between edges. `done` is due exactly one cycle after the final acknowledge, or one cycle after start when no bank is fitted. The bench notes the cycle of the final acknowledge and checks the pulse and the mask in the next cycle only, then checks one cycle later that the pulse is gone and the mask is unchanged. Random acknowledge delays of zero to two cycles exercise the hold-until-acknowledge rule without shifting when any result is due.

// File: rtl/erase_sched_pkg.sv
package erase_sched_pkg;

    typedef enum logic [1:0] {
        OP_SETUP   = 2'd0,
        OP_ADDR    = 2'd1,
        OP_CONFIRM = 2'd2,
        OP_STATUS  = 2'd3
    } op_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_POLL  = 2'd2
    } phase_t;

endpackage

// File: rtl/erase_bank_pick.sv
// Finds the lowest set bit of a mask at or above a starting index.
module erase_bank_pick #(
    parameter int NB = 4,
    localparam int BW = (NB > 1) ? $clog2(NB) : 1
) (
    input  logic [NB-1:0] mask,
    input  logic [BW:0]   from_idx,
    output logic          found,
    output logic [BW-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = NB - 1; i >= 0; i--) begin
            if (mask[i] && (i >= int'(from_idx))) begin
                found = 1'b1;
                idx   = BW'(i);
            end
        end
    end
endmodule

// File: rtl/erase_poll_timer.sv
// Counts not-ready status replies for the bank being polled.
module erase_poll_timer #(
    parameter int LIMIT = 1024,
    localparam int CW = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic expired
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)
            cnt_d = '0;
        else if (inc)
            cnt_d = cnt_q + CW'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == CW'(LIMIT - 1));
endmodule

// File: rtl/erase_op_encode.sv
// Turns phase and step into the operation presented to the sequencer.
module erase_op_encode
    import erase_sched_pkg::*;
#(
    parameter int ADDR_CYCLES = 2,
    localparam int STEPS = ADDR_CYCLES + 2,
    localparam int SW = $clog2(STEPS),
    localparam int ROW_W = 8 * ADDR_CYCLES
) (
    input  phase_t           phase,
    input  logic [SW-1:0]    step,
    input  logic [ROW_W-1:0] row,
    output logic             valid,
    output op_t              code,
    output logic [7:0]       data
);
    localparam logic [SW-1:0] LAST_STEP = SW'(STEPS - 1);

    always_comb begin
        valid = (phase != ST_IDLE);
        code  = OP_SETUP;
        data  = 8'h00;
        if (phase == ST_POLL) begin
            code = OP_STATUS;
        end else if (phase == ST_ISSUE) begin
            if (step == '0)
                code = OP_SETUP;
            else if (step == LAST_STEP)
                code = OP_CONFIRM;
            else
                code = OP_ADDR;
            for (int c = 0; c < ADDR_CYCLES; c++) begin
                if (step == SW'(c + 1))
                    data = row[8*c +: 8];
            end
        end
    end
endmodule

// File: rtl/erase_sched.sv
module erase_sched
    import erase_sched_pkg::*;
#(
    parameter int NBANK       = 4,
    parameter int ADDR_CYCLES = 2,
    parameter int POLL_LIMIT  = 1024,
    localparam int BW    = (NBANK > 1) ? $clog2(NBANK) : 1,
    localparam int ROW_W = 8 * ADDR_CYCLES,
    localparam int STEPS = ADDR_CYCLES + 2,
    localparam int SW    = $clog2(STEPS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [ROW_W-1:0] row_addr,
    input  logic [NBANK-1:0] bank_present,
    output logic             done,
    output logic [NBANK-1:0] fail_mask,
    output logic             op_valid,
    output logic [1:0]       op_code,
    output logic [BW-1:0]    op_bank,
    output logic [7:0]       op_data,
    input  logic             op_ack,
    input  logic             op_err,
    input  logic             op_ready
);
    localparam logic [SW-1:0] LAST_STEP = SW'(STEPS - 1);

    typedef struct packed {
        phase_t           phase;
        logic [BW-1:0]    bank;
        logic [SW-1:0]    step;
        logic [NBANK-1:0] present;
        logic [ROW_W-1:0] row;
        logic [NBANK-1:0] fail;
        logic             done;
    } regs_t;

    regs_t q, d;

    logic             tmr_expired;
    logic             tmr_clr;
    logic             tmr_inc;
    logic             ack_fail;
    logic             bank_end;
    logic [NBANK-1:0] fail_upd;
    logic [NBANK-1:0] live_mask;
    logic [NBANK-1:0] first_mask;
    logic             after_found, first_found;
    logic [BW-1:0]    after_idx, first_idx;
    logic [BW:0]      after_from;
    op_t              enc_code;
    logic [NBANK-1:0] present_lat;

    // Failure and end-of-bank events for the acknowledged operation
    always_comb begin
        ack_fail = op_ack && (op_err ||
                   ((q.phase == ST_POLL) && !op_ready && tmr_expired));
        bank_end = op_ack && (ack_fail ||
                   ((q.phase == ST_ISSUE) && (q.step == LAST_STEP)) ||
                   ((q.phase == ST_POLL) && op_ready));
        fail_upd = q.fail;
        for (int i = 0; i < NBANK; i++) begin
            if (ack_fail && (q.bank == BW'(i)))
                fail_upd[i] = 1'b1;
        end
        live_mask  = q.present & ~fail_upd;
        first_mask = (q.phase == ST_IDLE) ? bank_present : live_mask;
        after_from = {1'b0, q.bank} + (BW + 1)'(1);
    end

    erase_bank_pick #(.NB(NBANK)) u_pick_after (
        .mask     (live_mask),
        .from_idx (after_from),
        .found    (after_found),
        .idx      (after_idx)
    );

    erase_bank_pick #(.NB(NBANK)) u_pick_first (
        .mask     (first_mask),
        .from_idx ('0),
        .found    (first_found),
        .idx      (first_idx)
    );

    assign tmr_clr = (q.phase != ST_POLL) || bank_end;
    assign tmr_inc = (q.phase == ST_POLL) && op_ack && !op_ready;

    erase_poll_timer #(.LIMIT(POLL_LIMIT)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (tmr_clr),
        .inc     (tmr_inc),
        .expired (tmr_expired)
    );

    // Next-state computation
    always_comb begin
        d      = q;
        d.done = 1'b0;
        unique case (q.phase)
            ST_IDLE: begin
                if (start) begin
                    d.present = bank_present;
                    d.row     = row_addr;
                    d.fail    = '0;
                    d.step    = '0;
                    if (first_found) begin
                        d.phase = ST_ISSUE;
                        d.bank  = first_idx;
                    end else begin
                        d.done  = 1'b1;
                    end
                end
            end
            ST_ISSUE: begin
                d.fail = fail_upd;
                if (bank_end) begin
                    d.step = '0;
                    if (after_found) begin
                        d.bank = after_idx;
                    end else if (first_found) begin
                        d.phase = ST_POLL;
                        d.bank  = first_idx;
                    end else begin
                        d.phase = ST_IDLE;
                        d.done  = 1'b1;
                    end
                end else if (op_ack) begin
                    d.step = q.step + SW'(1);
                end
            end
            ST_POLL: begin
                d.fail = fail_upd;
                if (bank_end) begin
                    if (after_found) begin
                        d.bank = after_idx;
                    end else begin
                        d.phase = ST_IDLE;
                        d.done  = 1'b1;
                    end
                end
            end
            default: begin
                d.phase = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.phase   <= ST_IDLE;
            q.bank    <= '0;
            q.step    <= '0;
            q.present <= '0;
            q.row     <= '0;
            q.fail    <= '0;
            q.done    <= 1'b0;
        end else begin
            q <= d;
        end
    end

    erase_op_encode #(.ADDR_CYCLES(ADDR_CYCLES)) u_enc (
        .phase (q.phase),
        .step  (q.step),
        .row   (q.row),
        .valid (op_valid),
        .code  (enc_code),
        .data  (op_data)
    );

    assign op_code     = enc_code;
    assign op_bank     = q.bank;
    assign done        = q.done;
    assign fail_mask   = q.fail;
    assign present_lat = q.present;

endmodule

// File: rtl/erase_sched_chk.sv
module erase_sched_chk #(
    parameter int NBANK = 4,
    localparam int BW = (NBANK > 1) ? $clog2(NBANK) : 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [NBANK-1:0] bank_present,
    input logic             done,
    input logic [NBANK-1:0] fail_mask,
    input logic             op_valid,
    input logic [1:0]       op_code,
    input logic [BW-1:0]    op_bank,
    input logic [7:0]       op_data,
    input logic             op_ack,
    input logic [NBANK-1:0] present_lat
);
    // R3
    op_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !op_ack) |=> (op_valid && $stable(op_code) &&
                                   $stable(op_bank) && $stable(op_data)));

    // R4
    absent_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |-> present_lat[op_bank]);

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !op_valid);

    // R11
    empty_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !op_valid && (bank_present == '0)) |=>
            (done && (fail_mask == '0) && !op_valid));

    // R8
    fail_fitted_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ((fail_mask & ~present_lat) == '0));

    // R10
    busy_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> $stable(present_lat));
endmodule

bind erase_sched erase_sched_chk #(.NBANK(NBANK)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .bank_present (bank_present),
    .done         (done),
    .fail_mask    (fail_mask),
    .op_valid     (op_valid),
    .op_code      (op_code),
    .op_bank      (op_bank),
    .op_data      (op_data),
    .op_ack       (op_ack),
    .present_lat  (present_lat)
);

// File: tb/erase_sched_test.sv
`timescale 1ns/1ps
module erase_sched_test;
    localparam int NB  = 4;
    localparam int LIM = 6;
    localparam int MAXE = 64;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [15:0] row_addr = '0;
    logic [3:0] bank_present = '0;
    logic       done;
    logic [3:0] fail_mask;
    logic       op_valid;
    logic [1:0] op_code;
    logic [1:0] op_bank;
    logic [7:0] op_data;
    logic       op_ack = 1'b0;
    logic       op_err = 1'b0;
    logic       op_ready = 1'b0;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    int fail_step [NB];
    int ready_after [NB];
    bit stat_err [NB];

    int ex_code [MAXE];
    int ex_bank [MAXE];
    int ex_data [MAXE];
    bit ex_err [MAXE];
    bit ex_rdy [MAXE];
    int ex_n;
    logic [3:0] ex_mask;

    always #2.5 clk = ~clk;

    erase_sched #(.NBANK(NB), .ADDR_CYCLES(2), .POLL_LIMIT(LIM)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .row_addr(row_addr),
        .bank_present(bank_present), .done(done), .fail_mask(fail_mask),
        .op_valid(op_valid), .op_code(op_code), .op_bank(op_bank),
        .op_data(op_data), .op_ack(op_ack), .op_err(op_err),
        .op_ready(op_ready)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic add_op(input int code, input int bank, input int data,
                          input bit err, input bit rdy);
        ex_code[ex_n] = code;
        ex_bank[ex_n] = bank;
        ex_data[ex_n] = data;
        ex_err[ex_n]  = err;
        ex_rdy[ex_n]  = rdy;
        ex_n++;
    endtask

    // Expected operation list and result mask from R2, R5, R6, R7
    task automatic build(input logic [3:0] mask, input logic [15:0] row);
        ex_n = 0;
        ex_mask = '0;
        for (int b = 0; b < NB; b++) begin
            if (mask[b]) begin
                for (int s = 0; s < 4; s++) begin
                    int dat;
                    bit e;
                    dat = (s == 1) ? int'(row[7:0]) : (s == 2) ? int'(row[15:8]) : 0;
                    e = (fail_step[b] == s);
                    add_op((s == 0) ? 0 : (s == 3) ? 2 : 1, b, dat, e, 1'b0);
                    if (e) begin
                        ex_mask[b] = 1'b1;
                        break;
                    end
                end
            end
        end
        for (int b = 0; b < NB; b++) begin
            if (mask[b] && !ex_mask[b]) begin
                if (stat_err[b]) begin
                    add_op(3, b, 0, 1'b1, 1'b0);
                    ex_mask[b] = 1'b1;
                end else begin
                    bit got;
                    got = 1'b0;
                    for (int k = 0; k < LIM; k++) begin
                        got = (k == ready_after[b]);
                        add_op(3, b, 0, 1'b0, got);
                        if (got) break;
                    end
                    if (!got) ex_mask[b] = 1'b1;
                end
            end
        end
    endtask

    task automatic run_case(input logic [3:0] mask, input logic [15:0] row,
                            input bit noisy);
        int k;
        int cyc;
        int last_ack;
        int wait_n;
        int delay;
        bit seen_done;
        build(mask, row);
        @(negedge clk);
        start = 1'b1;
        bank_present = mask;
        row_addr = row;
        k = 0; cyc = 0; last_ack = 0; wait_n = 0; seen_done = 1'b0;
        delay = int'($urandom_range(0, 2));
        while (cyc < 2000) begin
            @(negedge clk);
            cyc++;
            start = 1'b0;
            op_ack = 1'b0;
            op_err = 1'b0;
            op_ready = 1'b0;
            if (noisy) row_addr = 16'($urandom);   // R12 row changes after start
            if (done) begin
                seen_done = 1'b1;
                break;
            end
            if (op_valid) begin
                if (wait_n < delay) begin
                    wait_n++;
                end else begin
                    if (k < ex_n) begin
                        chk(op_code == 2'(ex_code[k]), "R2 op code", op_code, ex_code[k]);
                        chk(op_bank == 2'(ex_bank[k]), "R4 op bank", op_bank, ex_bank[k]);
                        chk(op_data == 8'(ex_data[k]), "R12 op data", op_data, ex_data[k]);
                        op_err = ex_err[k];
                        op_ready = ex_rdy[k];
                    end else begin
                        chk(1'b0, "R5 extra op", k, ex_n);
                    end
                    op_ack = 1'b1;
                    last_ack = cyc;
                    k++;
                    wait_n = 0;
                    delay = int'($urandom_range(0, 2));
                end
                if (noisy && ($urandom_range(0, 5) == 0)) begin
                    start = 1'b1;                    // R10 start while busy
                    bank_present = 4'($urandom);
                end
            end
        end
        start = 1'b0;
        chk(seen_done, "R9 done seen", int'(seen_done), 1);
        chk(k == ex_n, "R6 op count", k, ex_n);
        if (ex_n == 0)
            chk(cyc == 1, "R11 empty done cycle", cyc, 1);
        else
            chk(cyc == last_ack + 1, "R9 done cycle", cyc, last_ack + 1);
        chk(fail_mask == ex_mask, "R8 fail mask", fail_mask, ex_mask);
        chk(!op_valid, "R9 idle at done", op_valid, 0);
        @(negedge clk);
        chk(!done, "R9 done width", done, 0);
        chk(fail_mask == ex_mask, "R8 mask held", fail_mask, ex_mask);
    endtask

    task automatic clear_cfg();
        for (int b = 0; b < NB; b++) begin
            fail_step[b] = -1;
            ready_after[b] = 0;
            stat_err[b] = 1'b0;
        end
    endtask

    initial begin
        void'($urandom(1234));
        clear_cfg();
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(done == 1'b0, "R1 done", done, 0);
        chk(op_valid == 1'b0, "R1 op_valid", op_valid, 0);
        chk(fail_mask == 4'h0, "R1 fail_mask", fail_mask, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!op_valid && !done, "R1 after reset", op_valid, 0);

        // R11 nothing fitted
        run_case(4'h0, 16'hABCD, 1'b0);
        // R2 all fitted, all ready at once
        run_case(4'hF, 16'h1234, 1'b0);
        // R4 sparse fitting
        run_case(4'b1010, 16'h5A0F, 1'b1);
        // R5 issue failure at each step
        for (int s = 0; s < 4; s++) begin
            clear_cfg();
            fail_step[1] = s;
            fail_step[3] = 3 - s;
            run_case(4'hF, 16'h8001 + 16'(s), 1'b1);
        end
        // R7 timeout and status error
        clear_cfg();
        ready_after[0] = LIM;
        ready_after[2] = LIM - 1;
        stat_err[3] = 1'b1;
        run_case(4'hF, 16'hC0DE, 1'b1);
        // R8 every bank fails
        clear_cfg();
        for (int b = 0; b < NB; b++) fail_step[b] = 0;
        run_case(4'hF, 16'hFFFF, 1'b0);
        // R8 mask cleared by next start
        clear_cfg();
        run_case(4'h3, 16'h0102, 1'b0);

        // random runs
        for (int n = 0; n < 40; n++) begin
            for (int b = 0; b < NB; b++) begin
                fail_step[b] = ($urandom_range(0, 3) == 0) ? int'($urandom_range(0, 3)) : -1;
                ready_after[b] = int'($urandom_range(0, LIM));
                stat_err[b] = ($urandom_range(0, 7) == 0);
            end
            run_case(4'($urandom), 16'($urandom), 1'b1);
        end

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule